// File: doc/BRIEF.md
# Hundredths-of-a-second stopwatch counter

This block keeps an elapsed time from 00.00 s to 59.99 s as four decimal digits. It runs directly from a fast system clock. An internal prescaler produces a single-cycle advance tick once every `TICK_PERIOD` clocks, so no divided clock is needed. With the default of 1,000,000 at 100 MHz, the lowest digit advances every 10 ms.

The digits form a cascade of modulo counters. The three lower digits count modulo 10 and the top digit counts modulo 6. A stage moves only when the tick is present, the run gate is open, and every stage below it sits at its maximum. A pause input closes the run gate, which freezes the digits while the prescaler keeps running. An asynchronous active-low reset clears the digits and the prescaler. The per-stage at-maximum flags are exported for use by a neighbouring display or by an alarm.

Top module: `hundredthsStopwatch`

## Requirements
- R1: The digits `digit0`, `digit1` and `digit2` each take values 0 to 9 only. A stage that advances from 9 goes to 0. From any other value it goes up by exactly 1.
- R2: `digit3` takes values 0 to 5 only. It advances from 5 to 0 and otherwise goes up by 1.
- R3: Bit k of `stageMax` is 1 exactly when digit k holds its maximum: 9 for bits 0 to 2, and 5 for bit 3. The flag does not depend on `pause` or on the tick.
- R4: Digit k (k ≥ 1) changes on a clock edge only if every lower digit held its maximum before that edge and the lowest digit was enabled on that edge.
- R5: At a rising clock edge where `pause` is 1, no digit changes.
- R6: The prescaler counts 0 to `TICK_PERIOD`-1 and wraps. The lowest digit can advance only on the edge where the prescaler holds `TICK_PERIOD`-1, so the lowest digit advances at most once every `TICK_PERIOD` clocks.
- R7: Driving `rstN` low clears all four digits and the prescaler at once, without waiting for a clock edge.
- R8: The prescaler keeps counting while `pause` is 1. After a pause, ticks keep the phase they had before it.
- R9: On the first enabled tick at 59.99, the counter goes to 00.00. No other output marks this wrap.
- R10: With `TICK_PERIOD` = 1, the tick is high on every cycle. The lowest digit then advances on every unpaused clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pause | input | 1 | 1 freezes all digits; the prescaler keeps running |
| digit0 | output | 4 | Hundredths digit, binary 0–9 |
| digit1 | output | 4 | Tenths digit, binary 0–9 |
| digit2 | output | 4 | Seconds units digit, binary 0–9 |
| digit3 | output | 4 | Seconds tens digit, binary 0–5 |
| stageMax | output | 4 | Bit k is 1 when digit k is at its maximum |

## Verification
The bench builds two copies of the block side by side. One uses `TICK_PERIOD` = 1, so the tick never drops. This lets the full 6000-state cascade, including the 59.99-to-00.00 wrap, be swept in a few thousand cycles while pauses are interleaved. The other uses `TICK_PERIOD` = 3, with a pause pattern that does not line up with the tick. This makes the prescaler phase across pauses and the spacing of digit advances visible at the ports. A mid-run asynchronous reset checks that both copies clear before the next clock edge.

// File: rtl/hundredthsStopwatchPkg.sv
package hundredthsStopwatchPkg;

  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 4;
  localparam int LOW_MOD    = 10;
  localparam int TOP_MOD    = 6;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic tick;  // one-cycle advance request from the prescaler
    logic run;   // low while the count is frozen
  } swStrobes_t;

  function automatic int stageModulus(input int idx);
    return (idx == NUM_DIGITS - 1) ? TOP_MOD : LOW_MOD;
  endfunction

endpackage

// File: rtl/swDigitStage.sv
module swDigitStage #(
  parameter int MODULUS = 10,
  parameter int WIDTH   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  output logic [WIDTH-1:0] value,
  output logic             atMax
);
  localparam logic [WIDTH-1:0] MAX_VAL = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] valueQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valueQ <= '0;
    end else if (advance) begin
      if (valueQ == MAX_VAL) valueQ <= '0;
      else                   valueQ <= valueQ + WIDTH'(1);
    end
  end

  assign value = valueQ;
  assign atMax = (valueQ == MAX_VAL);
endmodule

// File: rtl/swControl.sv
module swControl
  import hundredthsStopwatchPkg::*;
#(
  parameter int TICK_PERIOD = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pause,
  output swStrobes_t strobes
);
  localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

  logic [CW-1:0] preCount;
  logic          preWrap;

  assign preWrap = (preCount == LAST);

  // Free-running prescaler; pause never stops it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCount <= '0;
    else if (preWrap) preCount <= '0;
    else              preCount <= preCount + CW'(1);
  end

  always_comb begin
    strobes.tick = preWrap;
    strobes.run  = ~pause;
  end
endmodule

// File: rtl/swDatapath.sv
module swDatapath
  import hundredthsStopwatchPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  swStrobes_t                 strobes,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits,
  output logic [NUM_DIGITS-1:0]      atMax
);
  logic [NUM_DIGITS-1:0] stageEn;

  assign stageEn[0] = strobes.tick & strobes.run;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gStage
    if (g > 0) begin : gChain
      assign stageEn[g] = stageEn[g-1] & atMax[g-1];
    end
    swDigitStage #(
      .MODULUS(stageModulus(g)),
      .WIDTH  (DIGIT_W)
    ) stage_i (
      .clk    (clk),
      .rstN   (rstN),
      .advance(stageEn[g]),
      .value  (digits[g]),
      .atMax  (atMax[g])
    );
  end
endmodule

// File: rtl/hundredthsStopwatch.sv
module hundredthsStopwatch
  import hundredthsStopwatchPkg::*;
#(
  parameter int TICK_PERIOD = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pause,
  output logic [3:0] digit0,
  output logic [3:0] digit1,
  output logic [3:0] digit2,
  output logic [3:0] digit3,
  output logic [3:0] stageMax
);
  swStrobes_t strobes;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digits;

  swControl #(.TICK_PERIOD(TICK_PERIOD)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .pause  (pause),
    .strobes(strobes)
  );

  swDatapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .digits (digits),
    .atMax  (stageMax)
  );

  assign digit0 = digits[0];
  assign digit1 = digits[1];
  assign digit2 = digits[2];
  assign digit3 = digits[3];
endmodule

// File: rtl/hundredthsStopwatch_checker.sv
module hundredthsStopwatch_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pause,
  input logic [3:0] digit0,
  input logic [3:0] digit1,
  input logic [3:0] digit2,
  input logic [3:0] digit3,
  input logic [3:0] stageMax
);
  assert_low_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (digit0 <= 4'd9) && (digit1 <= 4'd9) && (digit2 <= 4'd9));

  assert_low_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (digit0 != $past(digit0)) |->
      ((digit0 == $past(digit0) + 4'd1) || ($past(digit0) == 4'd9 && digit0 == 4'd0)));

  assert_top_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    digit3 <= 4'd5);

  assert_top_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (digit3 != $past(digit3)) |->
      ((digit3 == $past(digit3) + 4'd1) || ($past(digit3) == 4'd5 && digit3 == 4'd0)));

  assert_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    stageMax == {digit3 == 4'd5, digit2 == 4'd9, digit1 == 4'd9, digit0 == 4'd9});

  assert_carry1_R4: assert property (@(posedge clk) disable iff (!rstN)
    (digit1 != $past(digit1)) |-> ($past(digit0) == 4'd9 && digit0 == 4'd0));

  assert_carry3_R4: assert property (@(posedge clk) disable iff (!rstN)
    (digit3 != $past(digit3)) |->
      ($past(digit2) == 4'd9 && $past(digit1) == 4'd9 && $past(digit0) == 4'd9));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    pause |=> $stable({digit3, digit2, digit1, digit0}));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(digit3) == 4'd5 && digit3 == 4'd0) |-> ({digit2, digit1, digit0} == 12'h000));
endmodule

bind hundredthsStopwatch hundredthsStopwatch_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .pause   (pause),
  .digit0  (digit0),
  .digit1  (digit1),
  .digit2  (digit2),
  .digit3  (digit3),
  .stageMax(stageMax)
);

// File: tb/hundredthsStopwatch_tb_top.sv
module hundredthsStopwatch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pauseFast = 1'b0;
  logic pauseSlow = 1'b0;
  logic [3:0] fd0, fd1, fd2, fd3, fMax;
  logic [3:0] sd0, sd1, sd2, sd3, sMax;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hundredthsStopwatch #(.TICK_PERIOD(1)) dut_i (
    .clk(clk), .rstN(rstN), .pause(pauseFast),
    .digit0(fd0), .digit1(fd1), .digit2(fd2), .digit3(fd3), .stageMax(fMax));

  hundredthsStopwatch #(.TICK_PERIOD(3)) dutSlow_i (
    .clk(clk), .rstN(rstN), .pause(pauseSlow),
    .digit0(sd0), .digit1(sd1), .digit2(sd2), .digit3(sd3), .stageMax(sMax));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] toDigits(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] toFlags(input int v);
    logic [15:0] d;
    d = toDigits(v);
    return {12'h000, d[15:12] == 4'd5, d[11:8] == 4'd9, d[7:4] == 4'd9, d[3:0] == 4'd9};
  endfunction

  int vFast = 0;
  int vSlow = 0;
  int pre = 0;
  bit wrapped = 0;

  initial begin
    // Reset state (R7)
    #1;
    chk("R7 fast reset digits", {fd3, fd2, fd1, fd0}, 16'h0000);
    chk("R7 slow reset digits", {sd3, sd2, sd1, sd0}, 16'h0000);
    chk("R3 reset flags", {12'h0, fMax}, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 8800; i++) begin
      if (i != 0) @(negedge clk);
      if (i == 2000) begin
        // Mid-run asynchronous clear (R7)
        rstN = 1'b0;
        #1;
        chk("R7 async clear fast", {fd3, fd2, fd1, fd0}, 16'h0000);
        chk("R7 async clear slow", {sd3, sd2, sd1, sd0}, 16'h0000);
        @(negedge clk);
        rstN = 1'b1;
        vFast = 0; vSlow = 0; pre = 0;
      end
      if (wrapped) begin
        chk("R9 wrap to 00.00", {fd3, fd2, fd1, fd0}, 16'h0000);
        wrapped = 0;
      end
      if (pauseFast) begin
        chk("R5 frozen digits", {fd3, fd2, fd1, fd0}, toDigits(vFast));
        chk("R3 flags while paused", {12'h0, fMax}, toFlags(vFast));
      end else begin
        chk("R1 R2 R4 R10 digits", {fd3, fd2, fd1, fd0}, toDigits(vFast));
        chk("R3 flags", {12'h0, fMax}, toFlags(vFast));
      end
      chk("R6 R8 slow digits", {sd3, sd2, sd1, sd0}, toDigits(vSlow));
      chk("R3 slow flags", {12'h0, sMax}, toFlags(vSlow));
      pauseFast = ((i % 97) >= 90);
      pauseSlow = ((i % 50) >= 35);
      @(posedge clk);
      if (!pauseFast) begin
        if (vFast == 5999) wrapped = 1;
        vFast = (vFast + 1) % 6000;
      end
      if (pre == 2 && !pauseSlow) vSlow = (vSlow + 1) % 6000;
      pre = (pre + 1) % 3;
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule